// File: doc/BRIEF.md
# Programmer-Side Read Lock for a One-Time-Programmable Store

This block sits between a device programmer and a model of a one-time-programmable byte store. The programmer reads and writes bytes one per cycle and marks each programming session with a begin pulse and an end pulse. Bits in the store can only move from 1 to 0, so writing a byte ANDs it into the cell. Outside a session the block simply passes programming and reading through.

To lock the store, the programmer first finishes one ordinary session. It then raises the lock-request line, starts a second session and writes the image again. If the session qualifies, a sticky lock flag is set when it ends. From then on every read returns all-ones. The programmer's verify step therefore fails, and that failure is how success shows up. The lock is refused in three cases: when every byte written in the session was FFh, when a read came before the first write (a blank-check, program, verify run), and when no ordinary session has been completed before. The lock flag and the session history are part of the non-volatile state. They survive the ordinary reset and are cleared only by a full re-initialise of the model, which also erases the store back to FFh.

The programmer's address space covers 0000h to 7FFFh. Only the lowest 2^MEM_AW bytes of it exist in the model.

Top module: `otp_read_guard`

## Requirements
- R1: After re-initialise and reset, `locked` is 0, `rd_valid` is 0 and every in-range byte reads back as FFh.
- R2: A read accepted in one cycle (rd_en high, wr_en low) gives `rd_valid` high with its data in the next cycle. A write stores the old byte AND `wdata`.
- R3: An address at or above 2^MEM_AW (256 by default) is outside the store. A write there changes nothing, and a read there returns FFh.
- R4: `locked` rises at the clock edge that samples `pass_end`, provided all of these hold: the session was begun with `sec_sel` high, it held at least one in-range write, no read came before its first write, the AND of its written bytes is not FFh, and an ordinary session had been completed earlier. `locked` rises at no other time.
- R5: While `locked` is 1, every read returns FFh with `rd_valid` high.
- R6: A lock-request session whose written bytes are all FFh leaves `locked` at 0.
- R7: A lock-request session that reads the store before its first write leaves `locked` at 0.
- R8: `sec_sel` is sampled only at `pass_begin`. A session begun with it low does not lock, even if it rises later in the session.
- R9: A lock-request session with no earlier completed ordinary session (one begun with `sec_sel` low and holding a write) leaves `locked` at 0.
- R10: `locked` and the stored bytes are kept through `rst_n`. Holding `init_n` low clears `locked` and erases every byte to FFh.
- R11: A cycle with both wr_en and rd_en high performs only the write, and `rd_valid` stays 0 in the next cycle.
- R12: Once set, `locked` stays 1 until `init_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of session and read-path state |
| init_n | input | 1 | Synchronous active-low full re-initialise of the model |
| pass_begin | input | 1 | Starts a programming session; samples sec_sel |
| pass_end | input | 1 | Ends the current session and settles the lock decision |
| sec_sel | input | 1 | Lock-request select |
| wr_en | input | 1 | Program the byte at addr |
| rd_en | input | 1 | Read the byte at addr |
| addr | input | ADDR_W | Programmer address (0000h..7FFFh) |
| wdata | input | 8 | Byte to program |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 8 | Read data, or FFh when locked or out of range |
| locked | output | 1 | Sticky read-lock flag |

## Verification
The lock decision is driven with five kinds of session, each differing from a qualifying one in a single respect: a correct lock pass, a pass of only FFh bytes, a pass with a blank-check read ahead of the writes, a pass whose select rose only after begin, and a lock pass with no earlier image. Together these show which condition, if any, the gate ignores. Read-back is tried on fresh, merged, out-of-range and locked addresses, which separates the AND merge from the lock masking and the window check. The sticky flag is checked across a plain reset and then across a re-initialise, so that the two clear paths are kept apart.

// File: rtl/otp_guard_pkg.sv
package otp_guard_pkg;

  localparam int DATA_W = 8;

  typedef logic [DATA_W-1:0] byte_t;

  // Per-session bookkeeping held by the tracker.
  typedef struct packed {
    logic  active;
    logic  req_lock;
    logic  wrote;
    logic  probed;
    byte_t and_acc;
  } session_t;

  localparam session_t SESSION_IDLE = '{
    active:   1'b0,
    req_lock: 1'b0,
    wrote:    1'b0,
    probed:   1'b0,
    and_acc:  '1
  };

  // One-time cells: a bit can only be cleared.
  function automatic byte_t otp_merge(input byte_t old_b, input byte_t new_b);
    return old_b & new_b;
  endfunction

  function automatic logic all_ones(input byte_t b);
    return &b;
  endfunction

  // What the programmer sees on a read.
  function automatic byte_t read_mask(input logic lock_q, input logic in_range,
                                      input byte_t raw);
    return (lock_q || !in_range) ? '1 : raw;
  endfunction

endpackage

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_guard_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              init_n,
  input  logic              wr_go,
  input  logic              rd_go,
  input  logic [MEM_AW-1:0] idx,
  input  byte_t             wdata,
  output byte_t             raw_q
);

  localparam int DEPTH = 1 << MEM_AW;

  byte_t cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!init_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (wr_go) begin
      cells[idx] <= otp_merge(cells[idx], wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (rd_go) raw_q <= cells[idx];
  end

endmodule

// File: rtl/otp_pass_tracker.sv
module otp_pass_tracker
  import otp_guard_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pass_begin,
  input  logic  pass_end,
  input  logic  sec_sel,
  input  logic  wr_hit,
  input  logic  rd_hit,
  input  byte_t wdata,
  input  logic  image_present,
  output logic  arm,
  output logic  mark_image
);

  session_t st;
  logic     closing;
  logic     qualifies;

  assign closing    = st.active && pass_end;
  assign qualifies  = st.req_lock && st.wrote && !st.probed &&
                      !all_ones(st.and_acc) && image_present;
  assign arm        = closing && qualifies;
  assign mark_image = closing && !st.req_lock && st.wrote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SESSION_IDLE;
    end else if (!st.active) begin
      if (pass_begin) begin
        st          <= SESSION_IDLE;
        st.active   <= 1'b1;
        st.req_lock <= sec_sel;
      end
    end else if (pass_end) begin
      st <= SESSION_IDLE;
    end else begin
      if (rd_hit && !st.wrote) st.probed <= 1'b1;
      if (wr_hit) begin
        st.wrote   <= 1'b1;
        st.and_acc <= st.and_acc & wdata;
      end
    end
  end

endmodule

// File: rtl/otp_lock_store.sv
module otp_lock_store (
  input  logic clk,
  input  logic init_n,
  input  logic arm,
  input  logic mark_image,
  output logic locked,
  output logic image_present
);

  // Non-volatile in the model: only the re-initialise clears it.
  always_ff @(posedge clk) begin
    if (!init_n) begin
      locked        <= 1'b0;
      image_present <= 1'b0;
    end else begin
      if (arm)        locked        <= 1'b1;
      if (mark_image) image_present <= 1'b1;
    end
  end

endmodule

// File: rtl/otp_read_guard.sv
module otp_read_guard
  import otp_guard_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_n,
  input  logic              pass_begin,
  input  logic              pass_end,
  input  logic              sec_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              locked
);

  logic  in_win;
  logic  wr_hit;
  logic  rd_go;
  logic  arm;
  logic  mark_image;
  logic  image_present;
  logic  lock_at_rd;
  logic  win_at_rd;
  byte_t raw_q;

  generate
    if (MEM_AW >= ADDR_W) begin : g_full_window
      assign in_win = 1'b1;
    end else begin : g_part_window
      assign in_win = (addr[ADDR_W-1:MEM_AW] == '0);
    end
  endgenerate

  assign wr_hit = wr_en && in_win;
  assign rd_go  = rd_en && !wr_en;

  otp_cell_array #(.MEM_AW(MEM_AW)) u_cells (
    .clk    (clk),
    .init_n (init_n),
    .wr_go  (wr_hit),
    .rd_go  (rd_go),
    .idx    (addr[MEM_AW-1:0]),
    .wdata  (wdata),
    .raw_q  (raw_q)
  );

  otp_pass_tracker u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .pass_begin    (pass_begin),
    .pass_end      (pass_end),
    .sec_sel       (sec_sel),
    .wr_hit        (wr_hit),
    .rd_hit        (rd_go),
    .wdata         (wdata),
    .image_present (image_present),
    .arm           (arm),
    .mark_image    (mark_image)
  );

  otp_lock_store u_lock (
    .clk           (clk),
    .init_n        (init_n),
    .arm           (arm),
    .mark_image    (mark_image),
    .locked        (locked),
    .image_present (image_present)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      lock_at_rd <= 1'b0;
      win_at_rd  <= 1'b0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) begin
        lock_at_rd <= locked;
        win_at_rd  <= in_win;
      end
    end
  end

  assign rd_data = read_mask(lock_at_rd, win_at_rd, raw_q);

endmodule

// File: rtl/otp_read_guard_chk.sv
module otp_read_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init_n,
  input logic       rd_en,
  input logic       wr_en,
  input logic       pass_end,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       locked,
  input logic       image_present,
  input logic       arm
);

  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
    (rd_en && !wr_en) |=> rd_valid);

  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
    (rd_en && wr_en) |=> !rd_valid);

  a_r5_locked_reads_ones: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
    (rd_valid && $past(locked)) |-> (rd_data == 8'hFF));

  a_r4_lock_needs_end: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
    $rose(locked) |-> $past(pass_end));

  a_r9_lock_needs_image: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
    $rose(locked) |-> $past(image_present));

  a_r4_arm_sets_lock: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
    arm |=> locked);

  a_r12_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n || !init_n)
    ($past(init_n) && $past(locked)) |-> locked);

endmodule

bind otp_read_guard otp_read_guard_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .init_n        (init_n),
  .rd_en         (rd_en),
  .wr_en         (wr_en),
  .pass_end      (pass_end),
  .rd_valid      (rd_valid),
  .rd_data       (rd_data),
  .locked        (locked),
  .image_present (image_present),
  .arm           (arm)
);

// File: tb/tb_otp_read_guard.sv
module tb_otp_read_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_n = 1'b0;
  logic        pass_begin = 1'b0;
  logic        pass_end = 1'b0;
  logic        sec_sel = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd_valid;
  logic [7:0]  rd_data;
  logic        locked;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  otp_read_guard dut (
    .clk(clk), .rst_n(rst_n), .init_n(init_n), .pass_begin(pass_begin),
    .pass_end(pass_end), .sec_sel(sec_sel), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .locked(locked)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: pops the scoreboard when the design presents read data.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected rd_valid", 8'd1, 8'd0);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [14:0] a, input logic [7:0] e, input string req);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic start_pass(input logic sec);
    @(negedge clk); pass_begin = 1'b1; sec_sel = sec;
    @(negedge clk); pass_begin = 1'b0;
  endtask

  task automatic stop_pass();
    @(negedge clk); pass_end = 1'b1;
    @(negedge clk); pass_end = 1'b0; sec_sel = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog", 8'd1, 8'd0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    init_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    check("R1 locked after init", {7'd0, locked}, 8'd0);
    check("R1 rd_valid idle", {7'd0, rd_valid}, 8'd0);
    rd(15'h0005, 8'hFF, "R1 blank byte");

    // R9: lock request before any image exists
    start_pass(1'b1); wr(15'h0010, 8'h55); stop_pass();
    check("R9 no image, no lock", {7'd0, locked}, 8'd0);

    // ordinary session builds the image
    start_pass(1'b0);
    wr(15'h0000, 8'h12); wr(15'h0001, 8'h34); wr(15'h0002, 8'hF0);
    stop_pass();
    rd(15'h0000, 8'h12, "R2 stored byte");
    rd(15'h0002, 8'hF0, "R2 stored byte");
    wr(15'h0002, 8'h0F);
    rd(15'h0002, 8'h00, "R2 AND merge");
    rd(15'h0010, 8'h55, "R2 earlier write kept");

    // R3 out of window
    wr(15'h1000, 8'h00);
    rd(15'h1000, 8'hFF, "R3 out of range read");
    rd(15'h0100, 8'hFF, "R3 first address past store");

    // R6 all-FFh session
    start_pass(1'b1); wr(15'h0000, 8'hFF); wr(15'h0001, 8'hFF); stop_pass();
    check("R6 blank image refused", {7'd0, locked}, 8'd0);
    rd(15'h0000, 8'h12, "R6 data unchanged");

    // R7 blank-check, program, verify
    start_pass(1'b1); rd(15'h0000, 8'h12, "R7 probe read");
    wr(15'h0000, 8'h12); rd(15'h0000, 8'h12, "R7 verify read");
    stop_pass();
    check("R7 combined sequence refused", {7'd0, locked}, 8'd0);

    // R8 select rises after begin
    start_pass(1'b0); sec_sel = 1'b1; wr(15'h0000, 8'h12); stop_pass();
    check("R8 late select ignored", {7'd0, locked}, 8'd0);

    // R11 simultaneous read and write
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = 15'h0003; wdata = 8'h77;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    check("R11 read dropped", {7'd0, rd_valid}, 8'd0);
    rd(15'h0003, 8'h77, "R11 write kept");

    // R4 qualifying lock session
    start_pass(1'b1); wr(15'h0000, 8'h12); wr(15'h0001, 8'h34); stop_pass();
    check("R4 lock set at end", {7'd0, locked}, 8'd1);
    rd(15'h0000, 8'hFF, "R5 locked read");
    rd(15'h0003, 8'hFF, "R5 locked read");

    // R10 plain reset keeps lock
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R10 lock survives reset", {7'd0, locked}, 8'd1);
    check("R12 lock still held", {7'd0, locked}, 8'd1);
    rd(15'h0001, 8'hFF, "R10 still masked");

    // R10 re-initialise clears everything
    @(negedge clk); init_n = 1'b0;
    @(negedge clk); init_n = 1'b1;
    check("R10 init clears lock", {7'd0, locked}, 8'd0);
    rd(15'h0000, 8'hFF, "R10 init erases");
    wr(15'h0000, 8'hAB);
    rd(15'h0000, 8'hAB, "R10 store usable after init");

    repeat (3) @(negedge clk);
    check("scoreboard drained", 8'(exp_q.size()), 8'd0);
    finish_run();
  end

endmodule